// File: doc/BRIEF.md
# Write-Only Serial Configurator for Two Converters

This block sends a short, fixed list of register writes to two analog-to-digital converter modules over a serial link. The link carries no return data. It has one shared serial clock, one shared data line and an active-low select for each converter. Because nothing comes back, register contents are never checked; the block only guarantees the shape and order of each write.

A single-cycle `start` pulse launches the sequence. In the system this pulse comes from the host opening its data channel. While the writes are in progress `busy` is high. After the last write `done` rises, and the acquisition path uses it as its enable. A `start` that arrives while the block is idle, including after `done`, replays the whole list. A `start` that arrives while `busy` is high has no effect. The serial clock runs at the system clock divided by `2*HALF_DIV`. One table entry controls the converters' test-pattern output, selected by the `TEST_PAT` parameter.

Top module: `spi_cfg_writer`

## Requirements
- R1: After reset `sclk`=0, `mosi`=0, `ce1_n`=1, `ce2_n`=1, `busy`=0 and `done`=0.
- R2: Each write is 16 bits, sent MSB first and sampled by the receiver on the rising `sclk` edge. Bit 15 is a write flag of 0, bits 14:8 are the 7-bit register address and bits 7:0 are the data.
- R3: During a write, only the select of that entry's target is low: `ce1_n` for target 0 and `ce2_n` for target 1. Both selects are never low together.
- R4: `sclk` idles low. Each of its high and low halves lasts `HALF_DIV` system clocks. `mosi` never changes while `sclk` is high.
- R5: The select falls `HALF_DIV` clocks before the first rising `sclk` edge of a write. It rises `HALF_DIV` clocks after the last falling edge.
- R6: Between two writes the selects stay high for `2*HALF_DIV` clocks.
- R7: Eight entries (target, address, data) are sent in this order: (0,0x00,0x80), (1,0x00,0x80), (0,0x01,0x00), (1,0x01,0x00), (0,0x02,0x01), (1,0x02,0x01), (0,0x03,{TEST_PAT,7'h00}), (1,0x03,{TEST_PAT,7'h00}).
- R8: `done` rises, and `busy` falls in the same cycle, `2*HALF_DIV` clocks after the last select release. `done` then holds until the next accepted start.
- R9: A `start` while `busy` is high is ignored. The list is sent exactly once per accepted start. A `start` while idle replays the full list and clears `done`.
- R10: `busy` goes high in the clock cycle after an accepted `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Pulse that launches the write sequence |
| sclk | output | 1 | Shared serial clock |
| mosi | output | 1 | Shared serial data out |
| ce1_n | output | 1 | Active-low select, converter 1 |
| ce2_n | output | 1 | Active-low select, converter 2 |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | All writes sent; enables acquisition |

## Verification
The assertions assume `start` may arrive at any time, including on every cycle of a running sequence. They assume nothing about its width, so they hold under repeated or stuck pulses. They do assume reset is held for at least one edge before any stimulus. The bench meets this by releasing reset only after several cycles. It then injects start pulses at random gaps while a sequence runs. The random gaps are bounded so that every stray pulse lands before the sequence ends, except for the directed restart after `done`.

// File: rtl/spi_cfg_writer.sv
module spi_cfg_writer #(
  parameter int   HALF_DIV = 4,
  parameter logic TEST_PAT = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic sclk,
  output logic mosi,
  output logic ce1_n,
  output logic ce2_n,
  output logic busy,
  output logic done
);

  localparam int NENT   = 8;
  localparam int IW     = $clog2(NENT);
  localparam int DW     = $clog2(HALF_DIV + 1);
  localparam int LAST_H = 34;

  function automatic logic [16:0] entry(input logic [IW-1:0] i);
    case (i)
      3'd0:    entry = {1'b0, 1'b0, 7'h00, 8'h80};
      3'd1:    entry = {1'b1, 1'b0, 7'h00, 8'h80};
      3'd2:    entry = {1'b0, 1'b0, 7'h01, 8'h00};
      3'd3:    entry = {1'b1, 1'b0, 7'h01, 8'h00};
      3'd4:    entry = {1'b0, 1'b0, 7'h02, 8'h01};
      3'd5:    entry = {1'b1, 1'b0, 7'h02, 8'h01};
      3'd6:    entry = {1'b0, 1'b0, 7'h03, TEST_PAT, 7'h00};
      default: entry = {1'b1, 1'b0, 7'h03, TEST_PAT, 7'h00};
    endcase
  endfunction

  logic [IW-1:0] idx;
  logic [5:0]    hcnt;
  logic [DW-1:0] div;
  logic          half_tick;
  logic [16:0]   cur;
  logic          in_bits, ce_act;

  assign half_tick = busy && (div == DW'(HALF_DIV - 1));
  assign cur       = entry(idx);
  assign in_bits   = busy && (hcnt <= 6'd31);
  assign ce_act    = busy && (hcnt <= 6'd32);
  assign sclk      = in_bits && hcnt[0];
  assign mosi      = in_bits && cur[4'd15 - hcnt[4:1]];
  assign ce1_n     = !(ce_act && !cur[16]);
  assign ce2_n     = !(ce_act &&  cur[16]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      done <= 1'b0;
      idx  <= '0;
      hcnt <= '0;
      div  <= '0;
    end else if (!busy) begin
      if (start) begin
        busy <= 1'b1;
        done <= 1'b0;
        idx  <= '0;
        hcnt <= '0;
        div  <= '0;
      end
    end else begin
      div <= half_tick ? '0 : div + 1'b1;
      if (half_tick) begin
        if (hcnt == 6'(LAST_H)) begin
          hcnt <= '0;
          if (idx == IW'(NENT - 1)) begin
            busy <= 1'b0;
            done <= 1'b1;
          end else begin
            idx <= idx + 1'b1;
          end
        end else begin
          hcnt <= hcnt + 1'b1;
        end
      end
    end
  end

  p_reset_idle_r1: assert property (@(posedge clk) $past(!rst_n) |-> !busy && !done && ce1_n && ce2_n);

  p_one_select_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({~ce1_n, ~ce2_n}) <= 1);

  p_sclk_needs_select_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sclk |-> !(ce1_n && ce2_n));

  p_mosi_hold_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk && $past(sclk)) |-> $stable(mosi));

  p_idle_lines_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !sclk && !mosi && ce1_n && ce2_n);

  p_done_on_finish_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  p_start_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !half_tick) |=> $stable(idx) && $stable(hcnt));

  p_busy_follows_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start) |=> busy && !done);

endmodule

// File: tb/tb_spi_cfg_writer.sv
module tb_spi_cfg_writer;
  localparam int CLK_PERIOD = 10;
  localparam int HD = 3;
  localparam logic TP = 1'b1;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic sclk, mosi, ce1_n, ce2_n, busy, done;

  int checks = 0, fails = 0;
  int cyc = 0, widx = 0;

  spi_cfg_writer #(.HALF_DIV(HD), .TEST_PAT(TP)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .sclk(sclk), .mosi(mosi),
    .ce1_n(ce1_n), .ce2_n(ce2_n), .busy(busy), .done(done));

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [16:0] expect_entry(input int i);
    logic [7:0] tpd;
    tpd = {TP, 7'h00};
    case (i % 8)
      0: return {1'b0, 1'b0, 7'h00, 8'h80};
      1: return {1'b1, 1'b0, 7'h00, 8'h80};
      2: return {1'b0, 1'b0, 7'h01, 8'h00};
      3: return {1'b1, 1'b0, 7'h01, 8'h00};
      4: return {1'b0, 1'b0, 7'h02, 8'h01};
      5: return {1'b1, 1'b0, 7'h02, 8'h01};
      6: return {1'b0, 1'b0, 7'h03, tpd};
      default: return {1'b1, 1'b0, 7'h03, tpd};
    endcase
  endfunction

  task automatic chk(input string req, input logic ok, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  logic p_sclk = 0, p_mosi = 0, p_ce1 = 1, p_ce2 = 1, p_done = 0;
  logic [15:0] shreg;
  int nbits = 0, tgt = 0, first_rise = 0;
  int t_fall = 0, t_rise = 0, t_sfall = 0, t_cerise = -1;
  logic monitor_on = 0;

  always @(negedge clk) begin
    cyc++;
    if (monitor_on) begin
      if (!ce1_n && !ce2_n) chk("R3 both selects low", 0, 0, 1);
      if (sclk && p_sclk && mosi != p_mosi) chk("R4 mosi moved while sclk high", 0, mosi, p_mosi);
      if ((p_ce1 && p_ce2) && !(ce1_n && ce2_n)) begin
        if (t_cerise >= 0 && widx % 8 != 0)
          chk("R6 gap between writes", cyc - t_cerise == 2*HD, cyc - t_cerise, 2*HD);
        t_fall = cyc; nbits = 0; first_rise = 1; shreg = '0;
        tgt = ce1_n ? 1 : 0;
      end
      if (sclk && !p_sclk) begin
        if (first_rise)
          chk("R5 select lead", cyc - t_fall == HD, cyc - t_fall, HD);
        else
          chk("R4 sclk period", cyc - t_rise == 2*HD, cyc - t_rise, 2*HD);
        first_rise = 0; t_rise = cyc;
        shreg = {shreg[14:0], mosi}; nbits++;
      end
      if (!sclk && p_sclk) begin
        chk("R4 sclk high width", cyc - t_rise == HD, cyc - t_rise, HD);
        t_sfall = cyc;
      end
      if (!(p_ce1 && p_ce2) && (ce1_n && ce2_n)) begin
        logic [16:0] e;
        e = expect_entry(widx);
        t_cerise = cyc;
        chk("R5 select trail", cyc - t_sfall == HD, cyc - t_sfall, HD);
        chk("R2 bit count", nbits == 16, nbits, 16);
        chk("R2/R7 word content", shreg == e[15:0], shreg, e[15:0]);
        chk("R3/R7 target select", tgt == int'(e[16]), tgt, e[16]);
        widx++;
      end
      if (done && !p_done) begin
        chk("R8 done delay", cyc - t_cerise == 2*HD, cyc - t_cerise, 2*HD);
        chk("R8 busy low with done", !busy, busy, 0);
      end
    end
    p_sclk = sclk; p_mosi = mosi; p_ce1 = ce1_n; p_ce2 = ce2_n; p_done = done;
  end

  task automatic pulse_start();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done();
    int guard = 0;
    while (!done && guard < 20000) begin
      @(negedge clk); guard++;
    end
    chk("R8 done reached", done, done, 1);
  endtask

  initial begin
    int seed_dummy;
    seed_dummy = $urandom(32'd2024);
    repeat (4) @(negedge clk);
    chk("R1 idle sclk", sclk == 0, sclk, 0);
    chk("R1 idle mosi", mosi == 0, mosi, 0);
    chk("R1 idle selects", ce1_n && ce2_n, {ce1_n, ce2_n}, 2'b11);
    chk("R1 busy/done low", !busy && !done, {busy, done}, 0);
    rst_n = 1'b1;
    monitor_on = 1;
    repeat (3) @(negedge clk);
    chk("R1 still idle after reset release", !busy && !done && ce1_n && ce2_n, busy, 0);

    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R10 busy after start", busy, busy, 1);
    for (int k = 0; k < 10; k++) begin
      repeat ($urandom_range(5, 50)) @(negedge clk);
      chk("R9 still busy before stray start", busy, busy, 1);
      pulse_start();
    end
    wait_done();
    chk("R7/R9 words in first run", widx == 8, widx, 8);
    repeat (200) @(negedge clk);
    chk("R8 done holds", done && !busy, done, 1);
    chk("R9 no replay without start", widx == 8, widx, 8);

    pulse_start();
    chk("R10 busy after restart", busy, busy, 1);
    chk("R9 done cleared on restart", !done, done, 0);
    start = 1'b1;
    repeat (40) @(negedge clk);
    start = 1'b0;
    wait_done();
    chk("R9 words after second run", widx == 16, widx, 16);
    repeat (20) @(negedge clk);
    chk("R4 lines idle at end", !sclk && !mosi && ce1_n && ce2_n, sclk, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    checks++; fails++;
    $display("FAIL watchdog expired, actual=hung expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule